// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Extend Flag

This block carries out the eight single-operand shift and rotate operations of an integer datapath: arithmetic left and right, logical left and right, plain rotate left and right, and rotate left and right through the extend bit. It acts on the low byte, word or whole 32-bit long of the operand. The bit count comes from the count input, and the incoming extend flag is taken into account. It returns the shifted value along with the five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C).

A request is presented with `in_valid` for one cycle. With the default configuration the result and flags are registered and appear with `out_valid` on the next cycle. A memory-operand mode fixes the operation to word size and a single bit, whatever the size and count inputs say. Operand bits above the selected size pass through unchanged.

Top module: `srx_shift_unit`

## Requirements
- R1: `size` selects the width: 0 = byte (MSB bit 7), 1 = word (MSB bit 15), 2 and 3 = long (MSB bit 31). Result bits above the selected width equal the operand bits.
- R2: `op` = 0 (arithmetic left) shifts a zero into bit 0. X and C both take the last bit shifted out of the MSB. V is 1 if the MSB differs from the operand's original MSB after any step of the shift.
- R3: `op` = 1 (arithmetic right) copies the MSB back into itself. X and C both take the last bit shifted out of bit 0. V is 0.
- R4: `op` = 2 (logical left) and `op` = 3 (logical right) fill with zero. X and C both take the last bit shifted out.
- R5: `op` = 4 (rotate left) and `op` = 5 (rotate right) rotate within the width. C takes the last bit rotated out, and X equals `x_in`.
- R6: `op` = 6 (extend rotate left) and `op` = 7 (extend rotate right) rotate a ring of width+1 bits, with X placed beyond the MSB. X and C both equal the last bit that moved into X.
- R7: For every operation, N equals the result bit at the selected MSB. Z is 1 exactly when the selected low bits of the result are all zero.
- R8: V is 0 for every operation other than arithmetic left.
- R9: A count of 0 leaves the result equal to the operand, leaves X equal to `x_in` and clears V. C is 0, except for the extend rotates, where C equals `x_in`.
- R10: The count is used in full (0 to 63), including counts larger than the width. For example, a logical left shift of a long by 63 gives zero with C = 0.
- R11: When `mem_mode` is 1, the unit works as a word-size operation with a count of 1, ignoring `size` and `count`.
- R12: `out_valid` is high in the cycle after `in_valid` and low otherwise. Reset clears `out_valid`, the result and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 32 | Value to shift or rotate |
| size | input | 2 | Width select (0 byte, 1 word, 2/3 long) |
| op | input | 3 | Operation code (0..7, see R2 to R6) |
| count | input | 6 | Number of bit steps |
| mem_mode | input | 1 | Memory-operand mode: word, one step |
| x_in | input | 1 | Incoming extend flag |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Shifted or rotated value |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench targets the cases where the flag rules for each operation diverge. An arithmetic left shift whose MSB flips and then flips back must keep V set; a design that only compares the final MSB would clear it. A zero count on an extend rotate must copy X into C, while other operations must clear C; a design with a common zero-count path would get one of these wrong. A plain rotate must leave X untouched, and an extend rotate of a byte by nine steps must bring the value back to where it started; a design that rotates only within the width would not. Byte operations with non-zero upper bits, memory mode with a conflicting size and count, and counts beyond the width show whether the design leaks into the upper bits or truncates the count.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      OP_SAL = 3'd0,
      OP_SAR = 3'd1,
      OP_SLL = 3'd2,
      OP_SLR = 3'd3,
      OP_ROL = 3'd4,
      OP_ROR = 3'd5,
      OP_RXL = 3'd6,
      OP_RXR = 3'd7
   } srx_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } srx_size_e;

   typedef struct packed {
      logic [31:0] data;
      logic        x;
      logic        c;
      logic        v;
   } srx_state_t;
endpackage

// File: rtl/srx_size_dec.sv
module srx_size_dec
   import srx_pkg::*;
(
   input  logic [1:0]  size_i,
   output logic [31:0] mask_o,
   output logic [4:0]  msb_o
);
   always_comb begin
      unique case (srx_size_e'(size_i))
         SZ_BYTE: begin mask_o = 32'h0000_00FF; msb_o = 5'd7;  end
         SZ_WORD: begin mask_o = 32'h0000_FFFF; msb_o = 5'd15; end
         default: begin mask_o = 32'hFFFF_FFFF; msb_o = 5'd31; end
      endcase
   end
endmodule

// File: rtl/srx_step.sv
module srx_step
   import srx_pkg::*;
(
   input  logic        en_i,
   input  srx_op_e     op_i,
   input  logic [31:0] mask_i,
   input  logic [4:0]  msb_i,
   input  logic        sgn0_i,
   input  srx_state_t  st_i,
   output srx_state_t  st_o
);
   logic        top_b;
   logic        bot_b;
   logic [31:0] shl;
   logic [31:0] shr;
   logic [31:0] nd;

   assign top_b = st_i.data[msb_i];
   assign bot_b = st_i.data[0];
   assign shl   = (st_i.data << 1) & mask_i;
   assign shr   = st_i.data >> 1;

   always_comb begin
      st_o = st_i;
      nd   = st_i.data;
      if (en_i) begin
         unique case (op_i)
            OP_SAL: begin
               nd     = shl;
               st_o.c = top_b;
               st_o.x = top_b;
               st_o.v = st_i.v | (nd[msb_i] != sgn0_i);
            end
            OP_SAR: begin
               nd     = shr | ({31'b0, top_b} << msb_i);
               st_o.c = bot_b;
               st_o.x = bot_b;
            end
            OP_SLL: begin
               nd     = shl;
               st_o.c = top_b;
               st_o.x = top_b;
            end
            OP_SLR: begin
               nd     = shr;
               st_o.c = bot_b;
               st_o.x = bot_b;
            end
            OP_ROL: begin
               nd     = shl | {31'b0, top_b};
               st_o.c = top_b;
            end
            OP_ROR: begin
               nd     = shr | ({31'b0, bot_b} << msb_i);
               st_o.c = bot_b;
            end
            OP_RXL: begin
               nd     = shl | {31'b0, st_i.x};
               st_o.c = top_b;
               st_o.x = top_b;
            end
            default: begin
               nd     = shr | ({31'b0, st_i.x} << msb_i);
               st_o.c = bot_b;
               st_o.x = bot_b;
            end
         endcase
         st_o.data = nd;
      end
   end
endmodule

// File: rtl/srx_shift_unit.sv
module srx_shift_unit
   import srx_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 6,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       operand,
   input  logic [1:0]        size,
   input  logic [2:0]        op,
   input  logic [CNT_W-1:0]  count,
   input  logic              mem_mode,
   input  logic              x_in,
   output logic              out_valid,
   output logic [31:0]       result,
   output logic              flag_x,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c
);
   localparam int STEPS = (1 << CNT_W) - 1;

   if (DATA_W != 32) begin : g_bad_width
      $error("srx_shift_unit: DATA_W must be 32 for byte/word/long sizes");
   end
   if (CNT_W < 1 || CNT_W > 6) begin : g_bad_cnt
      $error("srx_shift_unit: CNT_W must lie in 1..6");
   end

   srx_op_e           op_e;
   logic [1:0]        eff_size;
   logic [CNT_W-1:0]  eff_cnt;
   logic [31:0]       mask;
   logic [4:0]        msb;
   srx_state_t        chain [0:STEPS];

   assign op_e     = srx_op_e'(op);
   assign eff_size = mem_mode ? 2'(SZ_WORD) : size;
   assign eff_cnt  = mem_mode ? CNT_W'(1) : count;

   srx_size_dec u_dec (
      .size_i (eff_size),
      .mask_o (mask),
      .msb_o  (msb)
   );

   always_comb begin
      chain[0].data = operand & mask;
      chain[0].x    = x_in;
      chain[0].c    = (op_e == OP_RXL || op_e == OP_RXR) ? x_in : 1'b0;
      chain[0].v    = 1'b0;
   end

   for (genvar i = 0; i < STEPS; i++) begin : g_step
      srx_step u_step (
         .en_i   (32'(eff_cnt) > i),
         .op_i   (op_e),
         .mask_i (mask),
         .msb_i  (msb),
         .sgn0_i (operand[msb]),
         .st_i   (chain[i]),
         .st_o   (chain[i+1])
      );
   end

   logic [31:0] res_c;
   logic [31:0] low_c;
   assign low_c = chain[STEPS].data & mask;
   assign res_c = (operand & ~mask) | low_c;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_x    <= 1'b0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_v    <= 1'b0;
            flag_c    <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result <= res_c;
               flag_x <= chain[STEPS].x;
               flag_n <= res_c[msb];
               flag_z <= (low_c == '0);
               flag_v <= chain[STEPS].v;
               flag_c <= chain[STEPS].c;
            end
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = res_c;
      assign flag_x    = chain[STEPS].x;
      assign flag_n    = res_c[msb];
      assign flag_z    = (low_c == '0);
      assign flag_v    = chain[STEPS].v;
      assign flag_c    = chain[STEPS].c;
   end
endmodule

// File: rtl/srx_shift_unit_chk.sv
module srx_shift_unit_chk #(
   parameter int CNT_W   = 6,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [31:0]       operand,
   input logic [1:0]        size,
   input logic [2:0]        op,
   input logic [CNT_W-1:0]  count,
   input logic              mem_mode,
   input logic              x_in,
   input logic              out_valid,
   input logic [31:0]       result,
   input logic              flag_x,
   input logic              flag_n,
   input logic              flag_z,
   input logic              flag_v,
   input logic              flag_c
);
   if (REG_OUT) begin : g_props
      // R12
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R12
      valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      // R5
      rot_x_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (op == 3'd4 || op == 3'd5)) |=> (flag_x == $past(x_in)));
      // R8
      v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op != 3'd0) |=> !flag_v);
      // R9
      zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !mem_mode && count == '0) |=>
            (result == $past(operand) && flag_x == $past(x_in) && !flag_v));
      // R6
      rx_cx_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (op == 3'd6 || op == 3'd7)) |=> (flag_c == flag_x));
      // R1
      upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !mem_mode && size == 2'd0) |=>
            (result[31:8] == $past(operand[31:8])));
      // R11
      mem_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && mem_mode) |=> (result[31:16] == $past(operand[31:16])));
   end
endmodule

bind srx_shift_unit srx_shift_unit_chk #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_srx_shift_unit.sv
module tb_srx_shift_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] operand = '0;
   logic [1:0]  size = '0;
   logic [2:0]  op = '0;
   logic [5:0]  count = '0;
   logic        mem_mode = 1'b0;
   logic        x_in = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        flag_x, flag_n, flag_z, flag_v, flag_c;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   srx_shift_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
      .size(size), .op(op), .count(count), .mem_mode(mem_mode), .x_in(x_in),
      .out_valid(out_valid), .result(result), .flag_x(flag_x), .flag_n(flag_n),
      .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   // Packed {result, x, n, z, v, c}
   function automatic logic [36:0] model(input logic [2:0] mop, input logic [1:0] msz,
                                         input logic [5:0] mcnt, input logic mm,
                                         input logic xi, input logic [31:0] a);
      int w;
      int k;
      logic [31:0] v;
      logic x, c, vf, s0;
      w = mm ? 16 : (msz == 2'd0 ? 8 : (msz == 2'd1 ? 16 : 32));
      k = mm ? 1 : int'(mcnt);
      v = a;
      x = xi;
      vf = 1'b0;
      s0 = a[w-1];
      c = (mop >= 3'd6) ? xi : 1'b0;
      for (int i = 0; i < k; i++) begin
         logic hi, lo;
         logic [31:0] nv;
         hi = v[w-1];
         lo = v[0];
         nv = v;
         if (mop[0] == 1'b0) begin
            for (int j = w - 1; j > 0; j--) nv[j] = v[j-1];
            nv[0] = (mop == 3'd4) ? hi : ((mop == 3'd6) ? x : 1'b0);
            c = hi;
         end else begin
            for (int j = 0; j < w - 1; j++) nv[j] = v[j+1];
            nv[w-1] = (mop == 3'd1) ? hi : (mop == 3'd3) ? 1'b0 : (mop == 3'd5) ? lo : x;
            c = lo;
         end
         if (mop != 3'd4 && mop != 3'd5) x = c;
         if (mop == 3'd0 && nv[w-1] != s0) vf = 1'b1;
         v = nv;
      end
      begin
         logic [31:0] m;
         m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
         return {v, x, v[w-1], ((v & m) == 32'd0), vf, c};
      end
   endfunction

   task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual res=%h xnzvc=%b expected res=%h xnzvc=%b",
                  req, act[36:5], act[4:0], exp[36:5], exp[4:0]);
      end
   endtask

   task automatic run(input logic [2:0] o, input logic [1:0] s, input logic [5:0] n,
                      input logic m, input logic xi, input logic [31:0] a);
      @(negedge clk);
      op = o; size = s; count = n; mem_mode = m; x_in = xi; operand = a;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [36:0] outs();
      return {result, flag_x, flag_n, flag_z, flag_v, flag_c};
   endfunction

   task automatic t_reset();
      checks++;
      if (out_valid !== 1'b0 || outs() !== 37'd0) begin
         errors++;
         $display("FAIL R12 reset: actual valid=%b outs=%h expected 0", out_valid, outs());
      end
   endtask

   task automatic t_timing();
      run(3'd2, 2'd0, 6'd1, 1'b0, 1'b0, 32'h1);
      checks++;
      if (out_valid !== 1'b1) begin
         errors++; $display("FAIL R12 valid: actual %b expected 1", out_valid);
      end
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++; $display("FAIL R12 idle: actual %b expected 0", out_valid);
      end
   endtask

   task automatic t_arith();
      run(3'd0, 2'd0, 6'd1, 1'b0, 1'b0, 32'h40);
      check("R2 sal.b 1", outs(), {32'h80, 5'b01010});
      run(3'd0, 2'd0, 6'd2, 1'b0, 1'b0, 32'h40);
      check("R2 sal.b 2 sticky V", outs(), {32'h0, 5'b10111});
      run(3'd1, 2'd1, 6'd4, 1'b0, 1'b0, 32'h8000);
      check("R3 sar.w 4", outs(), {32'hF800, 5'b01000});
   endtask

   task automatic t_logical();
      run(3'd3, 2'd2, 6'd1, 1'b0, 1'b0, 32'h1);
      check("R4 slr.l 1", outs(), {32'h0, 5'b10101});
      run(3'd2, 2'd0, 6'd1, 1'b0, 1'b0, 32'hAABBCC01);
      check("R1 sll.b upper kept", outs(), {32'hAABBCC02, 5'b00000});
      run(3'd2, 2'd2, 6'd63, 1'b0, 1'b0, 32'hFFFFFFFF);
      check("R10 sll.l 63", outs(), {32'h0, 5'b00100});
   endtask

   task automatic t_rotate();
      run(3'd4, 2'd0, 6'd1, 1'b0, 1'b0, 32'h81);
      check("R5 rol.b 1", outs(), {32'h03, 5'b00001});
      run(3'd5, 2'd3, 6'd1, 1'b0, 1'b1, 32'h1);
      check("R5 ror.l x kept", outs(), {32'h80000000, 5'b11001});
   endtask

   task automatic t_rotx();
      run(3'd6, 2'd0, 6'd1, 1'b0, 1'b0, 32'h80);
      check("R6 rxl.b 1", outs(), {32'h0, 5'b10101});
      run(3'd7, 2'd0, 6'd9, 1'b0, 1'b0, 32'h01);
      check("R6 rxr.b 9 ring", outs(), {32'h01, 5'b00000});
   endtask

   task automatic t_zero();
      run(3'd2, 2'd0, 6'd0, 1'b0, 1'b1, 32'h55);
      check("R9 zero count sll", outs(), {32'h55, 5'b10000});
      run(3'd7, 2'd0, 6'd0, 1'b0, 1'b1, 32'h0);
      check("R9 zero count rxr", outs(), {32'h0, 5'b10101});
   endtask

   task automatic t_mem();
      run(3'd4, 2'd0, 6'd5, 1'b1, 1'b0, 32'h12348001);
      check("R11 mem rol", outs(), {32'h12340003, 5'b00001});
   endtask

   task automatic t_sweep();
      logic [31:0] pats [4];
      pats[0] = 32'hC3A5_5A81; pats[1] = 32'h0000_4000;
      pats[2] = 32'h7FFF_8001; pats[3] = 32'hF0F0_0F0F;
      for (int o = 0; o < 8; o++)
         for (int s = 0; s < 3; s++)
            for (int n = 0; n < 40; n += 3)
               for (int p = 0; p < 4; p++) begin
                  run(3'(o), 2'(s), 6'(n), 1'b0, 1'(p & 1), pats[p]);
                  check("R7 sweep", outs(), model(3'(o), 2'(s), 6'(n), 1'b0, 1'(p & 1), pats[p]));
               end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_timing();
      t_arith();
      t_logical();
      t_rotate();
      t_rotx();
      t_zero();
      t_mem();
      t_sweep();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule